// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day as a seconds count, a nanoseconds count and a sub-nanosecond fraction. On every edge of its own clock it adds a programmable period to that time. The period has an integer nanosecond part and a binary fraction of a nanosecond, so the rate can be trimmed in very fine steps. It serves as the timebase that hardware timestamping logic samples.

Software controls the counter through a small strobe-driven interface. It can program the period, load an absolute time, or request a single signed nanosecond offset that is folded into the next update. The block drives the current seconds and nanoseconds and a one-cycle strobe that marks each rollover of the seconds count.

A system reset enters through a chain of synchroniser flops. It is combined with a synchronous software reset, and both clear every register, including the period and any pending offset.

Top module: `ptp_tod_clock`

## Requirements
- R1: While reset is active, and after it is released, `tod_sec`, `tod_ns` and `pps` are zero. The asserting edge of `rst_n` takes effect at once. Its release passes through a two-flop synchroniser before the counter leaves reset.
- R2: On each clock edge with no load, the time advances by the stored period. Time counts in units of 2^-FRAC_W ns: the nanosecond part is `per_ns_in` and the fraction is `per_frac_in / 2^FRAC_W`. A carry out of the fraction adds one nanosecond.
- R3: `tod_ns` always stays below NS_PER_SEC. When an update reaches or passes NS_PER_SEC, NS_PER_SEC is subtracted and `tod_sec` rises by one in the same update.
- R4: `pps` is high for exactly the one cycle after an update that incremented `tod_sec`. It stays low after a load and after a seconds borrow.
- R5: When `set_en` is sampled high, the next outputs equal `set_sec` and `set_ns`, the fraction clears, and no period is added on that edge. A pending offset is discarded. Software keeps `set_ns` below NS_PER_SEC.
- R6: A period presented with `per_wr` high at an edge is stored at that edge. It first takes part in the update at the following edge.
- R7: An offset on `adj_ns` (two's complement, NS_W bits) with `adj_en` high is captured at one edge. It is added exactly once at the next edge, together with that edge's period, with a seconds carry or borrow as needed. Software keeps the period nanoseconds plus the offset magnitude below NS_PER_SEC.
- R8: `tod_sec` wraps modulo 2^SEC_W in both directions: an increment from all ones gives zero, and a borrow from zero gives all ones.
- R9: A `sw_rst` pulse sampled at an edge clears the time, the period and any pending offset. Afterwards the time holds at zero until a new period is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| per_wr | input | 1 | Period write strobe |
| per_ns_in | input | PER_NS_W | Whole nanoseconds per clock |
| per_frac_in | input | FRAC_W | Fractional nanoseconds per clock, units of 2^-FRAC_W ns |
| set_en | input | 1 | Absolute time load strobe |
| set_sec | input | SEC_W | Seconds value to load |
| set_ns | input | NS_W | Nanoseconds value to load |
| adj_en | input | 1 | One-shot offset strobe |
| adj_ns | input | NS_W | Signed nanosecond offset |
| tod_sec | output | SEC_W | Current seconds |
| tod_ns | output | NS_W | Current nanoseconds |
| pps | output | 1 | One-cycle seconds rollover strobe |

## Verification
The bench builds the counter with an 8-bit seconds field, 50 nanoseconds per second, a 4-bit fraction and a 4-bit period field. With these values every one of the 256 period codes can be swept. Rollovers and pps strobes occur every few cycles, and seconds wrap in both directions within a handful of updates. All offsets from -34 to +34 ns are applied around loads near both ends of the second. Expected values come from a single integer time in fractional units that is folded with division and modulo, not from a per-field carry chain.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

  // Result of folding a raw nanosecond sum back into one second.
  typedef struct packed {
    logic [63:0] ns;
    logic        carry;
    logic        borrow;
  } ns_fold_t;

  typedef enum logic [1:0] {
    UPD_STEP = 2'd0,
    UPD_LOAD = 2'd1
  } upd_kind_e;

  // raw is a two's complement sum. One fold is enough when the step stays
  // within one second in either direction.
  function automatic ns_fold_t fold_ns(input logic [63:0] raw,
                                       input logic [63:0] lim);
    ns_fold_t r;
    r.ns     = raw;
    r.carry  = 1'b0;
    r.borrow = 1'b0;
    if (raw[63]) begin
      r.ns     = raw + lim;
      r.borrow = 1'b1;
    end else if (raw >= lim) begin
      r.ns    = raw - lim;
      r.carry = 1'b1;
    end
    return r;
  endfunction

  // Sign-extend an NS_W-bit offset held in the low bits of a 64-bit word.
  function automatic logic [63:0] sext_to64(input logic [63:0] v,
                                            input int unsigned w);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    if (v[w-1]) return v | ~m;
    return v & m;
  endfunction

endpackage

// File: rtl/ptp_tod_rst_sync.sv
module ptp_tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  output logic rst_out
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  // Registered combine so the counter sees a clean, glitch-free reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_out <= 1'b1;
    else        rst_out <= ~chain[STAGES-1] | sw_rst;
  end

  // R9: a software reset sampled at an edge holds the counter in reset.
  p_sw_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_rst) |-> rst_out);

  // R1: release only after the synchroniser chain has filled.
  p_release_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out |-> $past(chain[STAGES-1]));

endmodule

// File: rtl/ptp_tod_ctrl.sv
module ptp_tod_ctrl #(
  parameter int PER_NS_W = 8,
  parameter int FRAC_W   = 32,
  parameter int NS_W     = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                per_wr,
  input  logic [PER_NS_W-1:0] per_ns_in,
  input  logic [FRAC_W-1:0]   per_frac_in,
  input  logic                adj_en,
  input  logic [NS_W-1:0]     adj_ns,
  output logic [PER_NS_W-1:0] per_ns_q,
  output logic [FRAC_W-1:0]   per_frac_q,
  output logic                adj_pend,
  output logic [NS_W-1:0]     adj_val
);

  // Period: cleared to zero by any reset, never kept across it.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      per_ns_q   <= '0;
      per_frac_q <= '0;
    end else if (per_wr) begin
      per_ns_q   <= per_ns_in;
      per_frac_q <= per_frac_in;
    end
  end

  // One-shot offset: held for a single cycle, then dropped.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      adj_pend <= 1'b0;
      adj_val  <= '0;
    end else begin
      adj_pend <= adj_en;
      adj_val  <= adj_en ? adj_ns : '0;
    end
  end

  // R6: a written period is visible one edge later.
  p_period_load_r6: assert property (@(posedge clk) disable iff (rst)
    per_wr |=> (per_ns_q == $past(per_ns_in)) && (per_frac_q == $past(per_frac_in)));

  // R7: a pending offset exists only right after a request.
  p_adj_once_r7: assert property (@(posedge clk) disable iff (rst)
    adj_pend |-> $past(adj_en));

endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 32,
  parameter int FRAC_W     = 32,
  parameter int PER_NS_W   = 8,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PER_NS_W-1:0] per_ns_q,
  input  logic [FRAC_W-1:0]   per_frac_q,
  input  logic                adj_pend,
  input  logic [NS_W-1:0]     adj_val,
  input  logic                set_en,
  input  logic [SEC_W-1:0]    set_sec,
  input  logic [NS_W-1:0]     set_ns,
  output logic [SEC_W-1:0]    tod_sec,
  output logic [NS_W-1:0]     tod_ns,
  output logic                pps
);

  localparam logic [63:0] NS_LIM = 64'(NS_PER_SEC);

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] frac_sum;
  logic              frac_carry;
  logic [63:0]       adj_ext;
  logic [63:0]       ns_raw;
  ns_fold_t          fold;
  logic              ns_carry;
  logic              ns_borrow;
  logic [SEC_W-1:0]  sec_step;
  upd_kind_e         upd;

  assign upd = set_en ? UPD_LOAD : UPD_STEP;

  always_comb begin
    {frac_carry, frac_sum} = {1'b0, frac_q} + {1'b0, per_frac_q};
    adj_ext   = adj_pend ? sext_to64(64'(adj_val), NS_W) : 64'd0;
    ns_raw    = 64'(tod_ns) + 64'(per_ns_q) + 64'(frac_carry) + adj_ext;
    fold      = fold_ns(ns_raw, NS_LIM);
    ns_carry  = fold.carry;
    ns_borrow = fold.borrow;
    if (ns_carry)       sec_step = tod_sec + SEC_W'(1);
    else if (ns_borrow) sec_step = tod_sec - SEC_W'(1);
    else                sec_step = tod_sec;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tod_sec <= '0;
      tod_ns  <= '0;
      frac_q  <= '0;
      pps     <= 1'b0;
    end else begin
      unique case (upd)
        UPD_LOAD: begin
          tod_sec <= set_sec;
          tod_ns  <= set_ns;
          frac_q  <= '0;
          pps     <= 1'b0;
        end
        default: begin
          tod_sec <= sec_step;
          tod_ns  <= NS_W'(fold.ns);
          frac_q  <= frac_sum;
          pps     <= ns_carry;
        end
      endcase
    end
  end

  // R3: nanoseconds never reach one full second.
  p_ns_range_r3: assert property (@(posedge clk) disable iff (rst)
    64'(tod_ns) < NS_LIM);

  // R4: the strobe marks a one-step seconds increment.
  p_pps_step_r4: assert property (@(posedge clk) disable iff (rst)
    pps |-> (tod_sec == SEC_W'($past(tod_sec) + SEC_W'(1))));

  // R5: a load shows the written time and no strobe.
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    $past(set_en) |-> (tod_sec == $past(set_sec)) && (tod_ns == $past(set_ns)) && !pps);

  // R8: seconds move only on a load, a carry or an offset.
  p_sec_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(set_en) && !$past(adj_pend) && !pps) |-> (tod_sec == $past(tod_sec)));

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
  parameter int SEC_W       = 48,
  parameter int NS_W        = 32,
  parameter int FRAC_W      = 32,
  parameter int PER_NS_W    = 8,
  parameter int NS_PER_SEC  = 1000000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_rst,
  input  logic                per_wr,
  input  logic [PER_NS_W-1:0] per_ns_in,
  input  logic [FRAC_W-1:0]   per_frac_in,
  input  logic                set_en,
  input  logic [SEC_W-1:0]    set_sec,
  input  logic [NS_W-1:0]     set_ns,
  input  logic                adj_en,
  input  logic [NS_W-1:0]     adj_ns,
  output logic [SEC_W-1:0]    tod_sec,
  output logic [NS_W-1:0]     tod_ns,
  output logic                pps
);

  logic                rst_int;
  logic [PER_NS_W-1:0] per_ns_q;
  logic [FRAC_W-1:0]   per_frac_q;
  logic                adj_pend;
  logic [NS_W-1:0]     adj_val;

  ptp_tod_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_rst  (sw_rst),
    .rst_out (rst_int)
  );

  ptp_tod_ctrl #(
    .PER_NS_W (PER_NS_W),
    .FRAC_W   (FRAC_W),
    .NS_W     (NS_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst_int),
    .per_wr      (per_wr),
    .per_ns_in   (per_ns_in),
    .per_frac_in (per_frac_in),
    .adj_en      (adj_en),
    .adj_ns      (adj_ns),
    .per_ns_q    (per_ns_q),
    .per_frac_q  (per_frac_q),
    .adj_pend    (adj_pend),
    .adj_val     (adj_val)
  );

  ptp_tod_core #(
    .SEC_W      (SEC_W),
    .NS_W       (NS_W),
    .FRAC_W     (FRAC_W),
    .PER_NS_W   (PER_NS_W),
    .NS_PER_SEC (NS_PER_SEC)
  ) u_core (
    .clk        (clk),
    .rst        (rst_int),
    .per_ns_q   (per_ns_q),
    .per_frac_q (per_frac_q),
    .adj_pend   (adj_pend),
    .adj_val    (adj_val),
    .set_en     (set_en),
    .set_sec    (set_sec),
    .set_ns     (set_ns),
    .tod_sec    (tod_sec),
    .tod_ns     (tod_ns),
    .pps        (pps)
  );

  // R1: outputs read zero whenever the internal reset is held.
  p_reset_zero_r1: assert property (@(posedge clk)
    rst_int |=> (rst_int -> (tod_sec == '0 && tod_ns == '0 && !pps)));

endmodule

// File: tb/ptp_tod_clock_tb_top.sv
`timescale 1ns/1ps
module ptp_tod_clock_tb_top;

  localparam int SEC_W = 8, NS_W = 32, FRAC_W = 4, PER_NS_W = 4, NSPS = 50;
  localparam longint U   = 64'd1 << FRAC_W;
  localparam longint NSL = NSPS;
  localparam longint R   = NSL * (64'd1 << SEC_W) * U;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sw_rst = 1'b0, per_wr = 1'b0, set_en = 1'b0, adj_en = 1'b0;
  logic [PER_NS_W-1:0] per_ns_in = '0;
  logic [FRAC_W-1:0]   per_frac_in = '0;
  logic [SEC_W-1:0]    set_sec = '0;
  logic [NS_W-1:0]     set_ns = '0, adj_ns = '0;
  logic [SEC_W-1:0]    tod_sec;
  logic [NS_W-1:0]     tod_ns;
  logic                pps;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference: one integer time in 2^-FRAC_W ns units, never split in fields.
  longint T = 0, m_per = 0, m_adj = 0;
  bit m_pend = 1'b0, pps_e = 1'b0;

  always #2.5 clk = ~clk;

  ptp_tod_clock #(
    .SEC_W (SEC_W), .NS_W (NS_W), .FRAC_W (FRAC_W),
    .PER_NS_W (PER_NS_W), .NS_PER_SEC (NSPS), .SYNC_STAGES (2)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .sw_rst (sw_rst), .per_wr (per_wr),
    .per_ns_in (per_ns_in), .per_frac_in (per_frac_in), .set_en (set_en),
    .set_sec (set_sec), .set_ns (set_ns), .adj_en (adj_en), .adj_ns (adj_ns),
    .tod_sec (tod_sec), .tod_ns (tod_ns), .pps (pps)
  );

  function automatic longint fdiv(longint a, longint b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  task automatic chk(string tag);
    longint tm, ns_e, sec_e;
    tm    = ((T % R) + R) % R;
    ns_e  = (tm / U) % NSL;
    sec_e = (tm / U) / NSL;
    checks++;
    if (longint'(tod_ns) != ns_e || longint'(tod_sec) != sec_e || pps != pps_e) begin
      errors++;
      $display("FAIL %s: sec/ns/pps got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, tod_sec, tod_ns, pps, sec_e, ns_e, pps_e);
    end
  endtask

  // One edge: advance the reference with the inputs held, then settle.
  task automatic tick();
    longint old;
    @(posedge clk);
    if (sw_rst) begin
      T = 0; m_per = 0; m_pend = 1'b0; m_adj = 0; pps_e = 1'b0;
    end else begin
      if (set_en) begin
        T = (longint'(set_sec) * NSL + longint'(set_ns)) * U;
        pps_e = 1'b0;
      end else begin
        old = T;
        T = T + m_per + (m_pend ? m_adj * U : 0);
        pps_e = (fdiv(T, U * NSL) == fdiv(old, U * NSL) + 1);
      end
      if (per_wr) m_per = longint'(per_ns_in) * U + longint'(per_frac_in);
      m_pend = adj_en;
      m_adj  = longint'($signed(adj_ns));
    end
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    per_wr = 1'b0; set_en = 1'b0; adj_en = 1'b0; sw_rst = 1'b0;
  endtask

  task automatic load(int s, int n, string tag);
    set_en = 1'b1; set_sec = SEC_W'(s); set_ns = NS_W'(n);
    tick(); chk(tag); clear_strobes();
  endtask

  task automatic wr_per(int pn, int pf);
    per_wr = 1'b1; per_ns_in = PER_NS_W'(pn); per_frac_in = FRAC_W'(pf);
    tick(); chk("R6 period write edge"); clear_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: zero in reset and after release with the synchroniser in the path.
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin tick(); chk("R1 after release"); end

    // R2 and R6: every period code, with the fraction carrying into ns.
    for (int pn = 0; pn < 16; pn++) begin
      for (int pf = 0; pf < 16; pf++) begin
        wr_per(pn, pf);
        for (int c = 0; c < 12; c++) begin tick(); chk("R2 sweep step, R3 wrap, R4 strobe"); end
      end
    end

    // R8 and R3: seconds wrap from all ones, with the strobe.
    wr_per(15, 0);
    load(255, 40, "R5 load near wrap");
    tick(); chk("R8 seconds wrap up, R3 fold, R4 pps");
    tick(); chk("R4 strobe one cycle");

    // R7: every offset around loads at both ends of the second.
    wr_per(3, 0);
    for (int a = -34; a <= 34; a++) begin
      load(5, (a < 0) ? 10 : 40, "R5 load before offset");
      adj_en = 1'b1; adj_ns = NS_W'(a);
      tick(); chk("R7 offset captured, not yet applied"); clear_strobes();
      tick(); chk("R7 offset applied once with carry or borrow");
      tick(); chk("R7 offset not repeated");
    end

    // R8: borrow below zero seconds wraps to all ones, no strobe.
    load(0, 2, "R5 load zero seconds");
    adj_en = 1'b1; adj_ns = NS_W'(-20);
    tick(); chk("R7 capture"); clear_strobes();
    tick(); chk("R8 seconds wrap down, R4 no pps on borrow");

    // R5: a load discards a pending offset.
    adj_en = 1'b1; adj_ns = NS_W'(20);
    tick(); chk("R7 capture before load"); clear_strobes();
    load(7, 1, "R5 load overrides pending offset");
    tick(); chk("R5 offset dropped after load");
    tick(); chk("R5 steady after load");

    // R9: software reset clears time, period and a pending offset.
    adj_en = 1'b1; adj_ns = NS_W'(9); sw_rst = 1'b1;
    tick(); chk("R9 software reset clears time"); clear_strobes();
    for (int i = 0; i < 6; i++) begin tick(); chk("R9 period and offset cleared"); end
    wr_per(1, 8);
    for (int i = 0; i < 20; i++) begin tick(); chk("R2 runs after new period"); end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule